// File: doc/BRIEF.md
# Byte-Lane Data Memory with Alignment Trap

This block is a data memory built as two parallel byte-wide halves that share a single word-index decode but are written through separate enables. A requester presents a 16-bit byte address with a read or a write strobe and a flag that selects a byte or a word access. Each word is stored little-endian: the even byte address holds the low byte and the odd byte address holds the high byte. A byte read fetches the whole word that contains the byte and presents the selected byte on the low eight bits of the read data. A byte write changes only the half that the address selects.

A word access at an odd address is misaligned and raises a one-cycle address-error trap. A misaligned read still returns data: the word that contains the addressed byte. A misaligned write is dropped. Only the window from `RAM_BASE` to `RAM_BASE + 2*RAM_WORDS - 1` is backed by storage. Reads anywhere else, including the unused register region 0x0000 to 0x0FFF, return zero, and writes there are discarded. Read data and the trap appear one clock after the access. In every other cycle the read data is zero.

Top module: `bldm_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdata` is 0x0000 and `addr_trap` is 0.
- R2: A word write to an even in-range address, followed by a word read of that address, returns the written 16-bit value on `rdata` in the cycle after the read strobe.
- R3: A byte read (`byte_mode`=1) returns the byte at the addressed location on `rdata[7:0]`: the low half of the word when address bit 0 is 0, the high half when it is 1. `rdata[15:8]` is zero.
- R4: A byte write stores `wdata[7:0]` only in the half chosen by address bit 0. The other byte of that word is unchanged.
- R5: A word access (`byte_mode`=0) with address bit 0 set raises `addr_trap` for exactly the one cycle after that access. Byte accesses and even word accesses never raise it.
- R6: A misaligned word read still completes. It returns the word at the address with bit 0 cleared.
- R7: A misaligned word write leaves the memory unchanged.
- R8: A read whose address is below `RAM_BASE` (this covers every address from 0x0000 to 0x0FFF) or at or above `RAM_BASE + 2*RAM_WORDS` returns 0x0000, for both byte and word reads.
- R9: A write to an address outside the implemented window changes no stored byte.
- R10: In a cycle that does not follow a read strobe, `rdata` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte address of the access |
| wdata | input | 16 | Write data. A byte write uses bits 7:0 |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| byte_mode | input | 1 | 1 = byte access, 0 = word access |
| rdata | output | 16 | Read data, valid the cycle after `rd` |
| addr_trap | output | 1 | Misalignment trap pulse, the cycle after the access |

## Verification
The assertions assume that `rd` and `wr` are never high in the same cycle, and one of them checks that assumption. They also assume that inputs are held at zero while reset is active. The bench issues exactly one operation per cycle and drives every strobe low during reset and idle cycles. The random addresses are weighted toward the implemented window. Some fall below it, into the register region, and some fall above it. The random choice of byte or word, together with random address parity, reaches both trap and non-trap cases.

// File: rtl/bldm_pkg.sv
package bldm_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;

  typedef struct packed {
    logic hit;       // address falls inside the storage window
    logic odd;       // byte address bit 0
    logic misalign;  // word access at an odd address
  } acc_dec_t;
endpackage

// File: rtl/bldm_decode.sv
module bldm_decode
  import bldm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BASE  = 16'h1000,
  parameter int unsigned RAM_WORDS = 256,
  parameter int unsigned IDX_W     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_mode,
  output acc_dec_t          dec,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0]   WIN_LO  = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0]   WIN_HI  = (ADDR_W+1)'(RAM_BASE + 2 * RAM_WORDS);
  localparam logic [ADDR_W-1:0] BASE_NR = ADDR_W'(RAM_BASE);

  logic [ADDR_W:0]   addr_ext;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    addr_ext     = {1'b0, addr};
    offset       = addr - BASE_NR;
    dec.hit      = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
    dec.odd      = addr[0];
    dec.misalign = !byte_mode && addr[0];
    idx          = offset[IDX_W:1];
  end
endmodule

// File: rtl/bldm_lane.sv
module bldm_lane
  import bldm_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] rbyte
);
  logic [LANE_W-1:0] mem [DEPTH];
  logic [LANE_W-1:0] rbyte_d;
  logic [LANE_W-1:0] rbyte_q;

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wbyte;
  end

  always_comb begin
    rbyte_d = rbyte_q;
    if (re) rbyte_d = mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbyte_q <= '0;
    else        rbyte_q <= rbyte_d;
  end

  assign rbyte = rbyte_q;
endmodule

// File: rtl/bldm_rdmux.sv
module bldm_rdmux
  import bldm_pkg::*;
(
  input  logic                    vld,
  input  logic                    hit,
  input  logic                    byte_mode,
  input  logic                    odd,
  input  logic [LANE_W-1:0]       lo_byte,
  input  logic [LANE_W-1:0]       hi_byte,
  output logic [LANES*LANE_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (vld && hit) begin
      if (byte_mode) rdata = {{LANE_W{1'b0}}, (odd ? hi_byte : lo_byte)};
      else           rdata = {hi_byte, lo_byte};
    end
  end
endmodule

// File: rtl/bldm_top.sv
module bldm_top
  import bldm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned RAM_BASE  = 16'h1000,
  parameter int unsigned RAM_WORDS = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd,
  input  logic                    wr,
  input  logic                    byte_mode,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    addr_trap
);
  localparam int unsigned IDX_W = $clog2(RAM_WORDS);
  localparam logic [ADDR_W:0] CHK_LO = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0] CHK_HI = (ADDR_W+1)'(RAM_BASE + 2 * RAM_WORDS);

  acc_dec_t          dec;
  logic [IDX_W-1:0]  idx;
  logic              wr_ok;
  logic [LANES-1:0]  lane_we;
  logic [LANE_W-1:0] lane_wbyte [LANES];
  logic [LANE_W-1:0] lane_rbyte [LANES];

  logic resp_vld_d, resp_vld_q;
  logic resp_hit_d, resp_hit_q;
  logic resp_byte_d, resp_byte_q;
  logic resp_odd_d, resp_odd_q;
  logic trap_d, trap_q;

  bldm_decode #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .byte_mode(byte_mode), .dec(dec), .idx(idx)
  );

  always_comb begin
    wr_ok         = wr && dec.hit && !dec.misalign;
    lane_we[0]    = wr_ok && (!byte_mode || !dec.odd);
    lane_we[1]    = wr_ok && (!byte_mode ||  dec.odd);
    lane_wbyte[0] = wdata[LANE_W-1:0];
    lane_wbyte[1] = byte_mode ? wdata[LANE_W-1:0] : wdata[2*LANE_W-1:LANE_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bldm_lane #(.DEPTH(RAM_WORDS), .IDX_W(IDX_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .we(lane_we[g]), .re(rd && dec.hit),
      .idx(idx), .wbyte(lane_wbyte[g]), .rbyte(lane_rbyte[g])
    );
  end

  always_comb begin
    resp_vld_d  = rd;
    resp_hit_d  = resp_hit_q;
    resp_byte_d = resp_byte_q;
    resp_odd_d  = resp_odd_q;
    if (rd) begin
      resp_hit_d  = dec.hit;
      resp_byte_d = byte_mode;
      resp_odd_d  = dec.odd;
    end
    trap_d = (rd || wr) && dec.misalign;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_vld_q  <= 1'b0;
      resp_hit_q  <= 1'b0;
      resp_byte_q <= 1'b0;
      resp_odd_q  <= 1'b0;
      trap_q      <= 1'b0;
    end else begin
      resp_vld_q  <= resp_vld_d;
      resp_hit_q  <= resp_hit_d;
      resp_byte_q <= resp_byte_d;
      resp_odd_q  <= resp_odd_d;
      trap_q      <= trap_d;
    end
  end

  bldm_rdmux u_mux (
    .vld(resp_vld_q), .hit(resp_hit_q), .byte_mode(resp_byte_q), .odd(resp_odd_q),
    .lo_byte(lane_rbyte[0]), .hi_byte(lane_rbyte[1]), .rdata(rdata)
  );

  assign addr_trap = trap_q;

  // Input assumption: one operation per cycle
  a_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n) !(rd && wr));

  // R5: a trap pulse follows only an odd word access
  a_r5_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    addr_trap |-> ($past(rd || wr) && !$past(byte_mode) && $past(addr[0])));

  // R4: a byte write drives at most one lane
  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && byte_mode) |-> ($countones(lane_we) <= 1));

  // R7: an odd word write never reaches the storage
  a_r7_no_misaligned_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !byte_mode && addr[0]) |-> (lane_we == '0));

  // R3: high byte is clear after a byte read
  a_r3_byte_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && byte_mode) |=> (rdata[2*LANE_W-1:LANE_W] == '0));

  // R8: reads outside the window return zero
  a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (({1'b0, addr} < CHK_LO) || ({1'b0, addr} >= CHK_HI))) |=> (rdata == '0));

  // R10: no read strobe, no data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));
endmodule

// File: tb/bldm_top_tb_top.sv
module bldm_top_tb_top;
  localparam int unsigned BASE  = 16'h1000;
  localparam int unsigned WORDS = 256;
  localparam int unsigned BYTES = 2 * WORDS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [15:0] wdata;
  logic        rd, wr, byte_mode;
  logic [15:0] rdata;
  logic        addr_trap;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [7:0]  model [BYTES];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  bldm_top #(.ADDR_W(16), .RAM_BASE(BASE), .RAM_WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd(rd), .wr(wr),
    .byte_mode(byte_mode), .rdata(rdata), .addr_trap(addr_trap)
  );

  function automatic bit in_win(input logic [15:0] a);
    return (int'(a) >= BASE) && (int'(a) < BASE + BYTES);
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a, input logic b);
    int off;
    if (!in_win(a)) return 16'h0000;
    off = int'(a) - BASE;
    if (b) return {8'h00, model[off]};
    off = off & ~1;
    return {model[off+1], model[off]};
  endfunction

  task automatic model_write(input logic [15:0] a, input logic b, input logic [15:0] d);
    int off;
    if (!in_win(a)) return;
    if (!b && a[0]) return;
    off = int'(a) - BASE;
    if (b) model[off] = d[7:0];
    else begin
      model[off]   = d[7:0];
      model[off+1] = d[15:8];
    end
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Drive one operation at a falling edge, check after the next rising edge.
  task automatic op(input logic r, input logic w, input logic b,
                    input logic [15:0] a, input logic [15:0] d, input string tag);
    logic [15:0] exp_d;
    logic        exp_t;
    exp_d = r ? exp_read(a, b) : 16'h0000;
    exp_t = (r || w) && !b && a[0];
    rd = r; wr = w; byte_mode = b; addr = a; wdata = d;
    @(negedge clk);
    check({tag, " data"}, rdata, exp_d);
    check("R5 trap", {15'd0, addr_trap}, {15'd0, exp_t});
    if (w) model_write(a, b, d);
    rd = 1'b0; wr = 1'b0;
  endtask

  task automatic idle_check();
    rd = 1'b0; wr = 1'b0;
    @(negedge clk);
    check("R10 idle", rdata, 16'h0000);
    check("R5 idle trap", {15'd0, addr_trap}, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] a;
    logic [15:0] d;
    void'($urandom(32'd4711));
    rst_n = 1'b0; rd = 1'b0; wr = 1'b0; byte_mode = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 reset data", rdata, 16'h0000);
    check("R1 reset trap", {15'd0, addr_trap}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset data", rdata, 16'h0000);
    check("R1 post-reset trap", {15'd0, addr_trap}, 16'h0000);

    for (int i = 0; i < WORDS; i++)
      op(1'b0, 1'b1, 1'b0, 16'(BASE + 2 * i), 16'($urandom()), "R2 fill");

    // Directed corner cases
    op(1'b0, 1'b1, 1'b0, 16'h1010, 16'hBEEF, "R2 write");
    op(1'b1, 1'b0, 1'b0, 16'h1010, 16'h0000, "R2 read");
    check("R2 literal", exp_read(16'h1010, 1'b0), 16'hBEEF);
    op(1'b0, 1'b1, 1'b1, 16'h1011, 16'hFF5A, "R4 byte write high");
    op(1'b1, 1'b0, 1'b0, 16'h1010, 16'h0000, "R4 other lane kept");
    check("R4 literal", exp_read(16'h1010, 1'b0), 16'h5AEF);
    op(1'b0, 1'b1, 1'b1, 16'h1010, 16'h0011, "R4 byte write low");
    op(1'b1, 1'b0, 1'b1, 16'h1011, 16'h0000, "R3 byte read odd");
    op(1'b1, 1'b0, 1'b1, 16'h1010, 16'h0000, "R3 byte read even");
    op(1'b0, 1'b1, 1'b0, 16'h1013, 16'h1234, "R7 misaligned write");
    op(1'b1, 1'b0, 1'b0, 16'h1012, 16'h0000, "R7 word unchanged");
    op(1'b1, 1'b0, 1'b0, 16'h1011, 16'h0000, "R6 misaligned read");
    op(1'b1, 1'b0, 1'b0, 16'h0800, 16'h0000, "R8 register region word");
    op(1'b1, 1'b0, 1'b1, 16'h0FFF, 16'h0000, "R8 register region byte");
    op(1'b1, 1'b0, 1'b0, 16'h1200, 16'h0000, "R8 above window");
    op(1'b1, 1'b0, 1'b1, 16'hFFFF, 16'h0000, "R8 top byte");
    op(1'b0, 1'b1, 1'b0, 16'h1200, 16'h7777, "R9 write above");
    op(1'b0, 1'b1, 1'b0, 16'h0000, 16'h6666, "R9 write below");
    op(1'b1, 1'b0, 1'b0, 16'h1000, 16'h0000, "R9 no alias");
    op(1'b1, 1'b0, 1'b0, 16'h11FE, 16'h0000, "R2 last word");
    op(1'b1, 1'b0, 1'b0, 16'h11FF, 16'h0000, "R6 misaligned last");
    idle_check();

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned sel;
      logic r, b;
      sel = $urandom_range(0, 99);
      if (sel < 70)      a = 16'(BASE + $urandom_range(0, BYTES - 1));
      else if (sel < 85) a = 16'($urandom_range(0, BASE - 1));
      else               a = 16'($urandom_range(BASE + BYTES, 16'hFFFF));
      d = 16'($urandom());
      r = $urandom_range(0, 1) == 1;
      b = $urandom_range(0, 1) == 1;
      if (!in_win(a))      op(r, !r, b, a, d, r ? "R8 rand" : "R9 rand");
      else if (!b && a[0]) op(r, !r, b, a, d, r ? "R6 rand" : "R7 rand");
      else if (b)          op(r, !r, b, a, d, r ? "R3 rand" : "R4 rand");
      else                 op(r, !r, b, a, d, "R2 rand");
      if ($urandom_range(0, 9) == 0) idle_check();
    end

    // Sweep the window to catch any corrupted byte
    for (int i = 0; i < WORDS; i++)
      op(1'b1, 1'b0, 1'b0, 16'(BASE + 2 * i), 16'h0000, "R9 final sweep");
    idle_check();
    summary();
  end
endmodule